// File: doc/BRIEF.md
# Shadowed Output Pattern Update Controller

This block keeps the 6-bit output-enable pattern that drives a multi-channel PWM stage and controls when a new pattern takes effect. Software writes the next pattern into a shadow register at any time. The active pattern changes only through a two-step handshake with the timer events. First, a selectable trigger sets a pending-request flag. That trigger is either a hardware switching event or a software write flagged with a request bit. Second, a separately selectable synchronization event copies shadow to active and drops the flag in the same cycle. Because the copy waits for a timer zero-match, a new pattern starts on a PWM period boundary.

A direct synchronization mode performs the copy as soon as a request exists. Combined with the software request bit, this puts the update entirely under software control. An idle input forces the active pattern to zero. The timers and the Hall-input decoder are outside the block. Each is seen only as a single-cycle event strobe.

Top module: `mcp_update_ctrl`

## Requirements
- R1: After reset the active pattern, the shadow pattern and the pending flag are all zero.
- R2: Trigger selector encoding `trig_sel_i`: 1 = timer A period-match counting up, 2 = timer A one-match counting down, 3 = timer B period-match, 4 = Hall event, 5 = timer A channel-1 compare. Values 0, 6 and 7 select nothing. Only a strobe of the selected event sets the pending flag, one cycle later.
- R3: Synchronization selector encoding `sync_sel_i`: 1 = timer A zero-match, 2 = timer B zero-match. When a request is pending and the selected zero-match strobes, shadow is copied to active and the pending flag clears, both visible one cycle later. The zero-match that is not selected has no effect.
- R4: With `sync_sel_i` = 3 (direct), a request is carried out in the cycle it arrives. Active takes the shadow value one cycle later, and the pending flag stays zero.
- R5: A write (`sw_wr_i`) with `sw_req_i` = 1 loads the shadow register and raises a request. If a copy happens in that same cycle, the newly written pattern is the one copied.
- R6: With `sync_sel_i` = 0, no copy happens. A pending request stays set until a synchronization source is selected.
- R7: If a request and the selected zero-match arrive in the same cycle, the copy happens in that cycle and the pending flag ends up clear.
- R8: While `idle_i` is high, the active pattern is cleared on the next edge. This takes priority over a simultaneous copy, and the pending request is kept for a later copy.
- R9: A write with `sw_req_i` = 0 loads only the shadow register. It neither changes the active pattern nor raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_sel_i | input | 3 | Trigger event selector |
| sync_sel_i | input | 2 | Synchronization event selector |
| ta_pm_up_i | input | 1 | Timer A period-match while counting up, strobe |
| ta_om_dn_i | input | 1 | Timer A one-match while counting down, strobe |
| tb_pm_i | input | 1 | Timer B period-match, strobe |
| hall_evt_i | input | 1 | Hall pattern event, strobe |
| ta_cc1_i | input | 1 | Timer A channel-1 compare match, strobe |
| ta_zm_i | input | 1 | Timer A zero-match, strobe |
| tb_zm_i | input | 1 | Timer B zero-match, strobe |
| sw_wr_i | input | 1 | Software write to the shadow pattern |
| sw_pat_i | input | 6 | Pattern written to the shadow register |
| sw_req_i | input | 1 | Transfer request bit sent with the write |
| idle_i | input | 1 | Idle: clears the active pattern |
| act_pat_o | output | 6 | Active output-enable pattern |
| pend_o | output | 1 | Pending-request flag |

## Verification
The bench builds the block with its default 6-bit pattern width and the five-entry trigger list. Every trigger code, including the three that select nothing, can therefore be exercised one by one against all five event strobes. With the narrow pattern, distinct values per trial make it visible which write was copied. The corner cases reached this way are:
- a request that coincides with its zero-match;
- idle overriding a copy while the request survives;
- a write whose data is forwarded into a same-cycle direct copy.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int PAT_W     = 6;
  localparam int N_TRG_EVT = 5;
  localparam int TSEL_W    = 3;
  localparam int SSEL_W    = 2;

  // trigger codes; event index k (0-based) is selected by code k+1
  localparam logic [TSEL_W-1:0] TRG_NONE     = 3'd0;
  localparam logic [TSEL_W-1:0] TRG_A_PM_UP  = 3'd1;
  localparam logic [TSEL_W-1:0] TRG_A_OM_DN  = 3'd2;
  localparam logic [TSEL_W-1:0] TRG_B_PM     = 3'd3;
  localparam logic [TSEL_W-1:0] TRG_HALL     = 3'd4;
  localparam logic [TSEL_W-1:0] TRG_A_CC1    = 3'd5;

  typedef enum logic [SSEL_W-1:0] {
    SYN_NONE   = 2'd0,
    SYN_A_ZERO = 2'd1,
    SYN_B_ZERO = 2'd2,
    SYN_DIRECT = 2'd3
  } sync_sel_e;
endpackage

// File: rtl/mcp_trig_sel.sv
module mcp_trig_sel
  import mcp_pkg::*;
#(
  parameter int N_EVT = N_TRG_EVT,
  parameter int SEL_W = TSEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_EVT-1:0] evt_i,
  output logic             hit_o
);
  logic [N_EVT-1:0] match;

  for (genvar g = 0; g < N_EVT; g++) begin : g_match
    localparam logic [SEL_W-1:0] CODE = SEL_W'(g + 1);
    assign match[g] = evt_i[g] & (sel_i == CODE);
  end

  assign hit_o = |match;
endmodule

// File: rtl/mcp_sync_sel.sv
module mcp_sync_sel
  import mcp_pkg::*;
(
  input  logic [SSEL_W-1:0] sel_i,
  input  logic              ta_zm_i,
  input  logic              tb_zm_i,
  input  logic              pend_i,
  input  logic              arm_i,
  input  logic              idle_i,
  output logic              copy_o
);
  logic sync_hit;

  always_comb begin
    unique case (sync_sel_e'(sel_i))
      SYN_A_ZERO: sync_hit = ta_zm_i;
      SYN_B_ZERO: sync_hit = tb_zm_i;
      SYN_DIRECT: sync_hit = 1'b1;
      default:    sync_hit = 1'b0;
    endcase
  end

  // idle wins over copy; request stays for later
  assign copy_o = (pend_i | arm_i) & sync_hit & ~idle_i;
endmodule

// File: rtl/mcp_pat_regs.sv
module mcp_pat_regs
  import mcp_pkg::*;
#(
  parameter int W = PAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_wr_i,
  input  logic [W-1:0] sw_pat_i,
  input  logic         arm_i,
  input  logic         copy_i,
  input  logic         idle_i,
  output logic [W-1:0] act_o,
  output logic         pend_o
);
  logic [W-1:0] shd_q, act_q, src;
  logic         pend_q;

  // same-cycle write is forwarded into the copy
  assign src = sw_wr_i ? sw_pat_i : shd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shd_q <= '0;
    else if (sw_wr_i) shd_q <= sw_pat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (idle_i) act_q <= '0;
    else if (copy_i) act_q <= src;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (copy_i)  pend_q <= 1'b0;
    else if (arm_i)   pend_q <= 1'b1;
  end

  assign act_o  = act_q;
  assign pend_o = pend_q;

  // R8
  idle_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (act_q == '0));

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !copy_i) |=> $stable(act_q));

  // R2
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !copy_i) |=> pend_q);

  // R3
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_i |=> !pend_q);

  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !copy_i) |=> $stable(pend_q));
endmodule

// File: rtl/mcp_update_ctrl.sv
module mcp_update_ctrl
  import mcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TSEL_W-1:0] trig_sel_i,
  input  logic [SSEL_W-1:0] sync_sel_i,
  input  logic              ta_pm_up_i,
  input  logic              ta_om_dn_i,
  input  logic              tb_pm_i,
  input  logic              hall_evt_i,
  input  logic              ta_cc1_i,
  input  logic              ta_zm_i,
  input  logic              tb_zm_i,
  input  logic              sw_wr_i,
  input  logic [PAT_W-1:0]  sw_pat_i,
  input  logic              sw_req_i,
  input  logic              idle_i,
  output logic [PAT_W-1:0]  act_pat_o,
  output logic              pend_o
);
  logic [N_TRG_EVT-1:0] trg_evt;
  logic                 hw_hit, sw_arm, arm, copy_en;

  // order follows trigger code - 1
  assign trg_evt = {ta_cc1_i, hall_evt_i, tb_pm_i, ta_om_dn_i, ta_pm_up_i};
  assign sw_arm  = sw_wr_i & sw_req_i;
  assign arm     = hw_hit | sw_arm;

  mcp_trig_sel #(.N_EVT(N_TRG_EVT), .SEL_W(TSEL_W)) u_trig (
    .sel_i (trig_sel_i),
    .evt_i (trg_evt),
    .hit_o (hw_hit)
  );

  mcp_sync_sel u_sync (
    .sel_i   (sync_sel_i),
    .ta_zm_i (ta_zm_i),
    .tb_zm_i (tb_zm_i),
    .pend_i  (pend_o),
    .arm_i   (arm),
    .idle_i  (idle_i),
    .copy_o  (copy_en)
  );

  mcp_pat_regs #(.W(PAT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_wr_i  (sw_wr_i),
    .sw_pat_i (sw_pat_i),
    .arm_i    (arm),
    .copy_i   (copy_en),
    .idle_i   (idle_i),
    .act_o    (act_pat_o),
    .pend_o   (pend_o)
  );

  // R4
  direct_nopend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_sel_i == 2'd3 && arm && !idle_i) |=> !pend_o);

  // R6
  nosync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_sel_i == 2'd0 && !idle_i) |=> $stable(act_pat_o));

  // R5
  sw_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && sw_req_i && sync_sel_i == 2'd3 && !idle_i)
      |=> (act_pat_o == $past(sw_pat_i)));
endmodule

// File: tb/mcp_update_ctrl_tb_top.sv
module mcp_update_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] trig_sel = '0;
  logic [1:0] sync_sel = '0;
  logic [4:0] evt = '0;  // index k = trigger code k+1
  logic       ta_zm = 0, tb_zm = 0, sw_wr = 0, sw_req = 0, idle = 0;
  logic [5:0] sw_pat = '0;
  logic [5:0] act;
  logic       pend;
  int         n_chk = 0, n_err = 0;
  logic [5:0] cur;  // expected active pattern

  always #2 clk = ~clk;

  mcp_update_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_sel_i(trig_sel), .sync_sel_i(sync_sel),
    .ta_pm_up_i(evt[0]), .ta_om_dn_i(evt[1]), .tb_pm_i(evt[2]),
    .hall_evt_i(evt[3]), .ta_cc1_i(evt[4]), .ta_zm_i(ta_zm), .tb_zm_i(tb_zm),
    .sw_wr_i(sw_wr), .sw_pat_i(sw_pat), .sw_req_i(sw_req), .idle_i(idle),
    .act_pat_o(act), .pend_o(pend)
  );

  task automatic chk(string req, logic [5:0] a, logic [5:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, a, e);
    end
  endtask

  // one edge; strobes cleared after it; sample 1 ns past the edge
  task automatic step();
    @(posedge clk); #1;
    evt = '0; ta_zm = 0; tb_zm = 0; sw_wr = 0; sw_req = 0;
  endtask

  task automatic wr(logic [5:0] p, logic req);
    sw_wr = 1; sw_pat = p; sw_req = req; step();
  endtask

  task automatic t_reset();
    chk("R1 act", act, 6'h00);
    chk("R1 pend", {5'b0, pend}, 6'h01 & 6'h00);
    // direct copy of untouched shadow must give zero
    trig_sel = 3'd1; sync_sel = 2'd3; evt[0] = 1; step();
    chk("R1 shadow", act, 6'h00);
    chk("R1 pend after", {5'b0, pend}, 6'h00);
    cur = 6'h00;
  endtask

  task automatic t_trig();
    for (int s = 1; s <= 5; s++) begin
      logic [5:0] p;
      p = 6'(s * 7 + 3);
      trig_sel = 3'(s); sync_sel = 2'd0;
      wr(p, 0);
      for (int k = 0; k < 5; k++) begin
        if (k != s - 1) evt[k] = 1;
      end
      step();
      chk("R2 unselected", {5'b0, pend}, 6'h00);
      evt[s-1] = 1; step();
      chk("R2 selected", {5'b0, pend}, 6'h01);
      chk("R6 no copy", act, cur);
      sync_sel = 2'd1; ta_zm = 1; step();
      chk("R3 copy A", act, p);
      chk("R3 pend clr", {5'b0, pend}, 6'h00);
      cur = p;
    end
    for (int s = 6; s <= 8; s++) begin
      trig_sel = 3'(s % 8); sync_sel = 2'd0; evt = '1; step();
      chk("R2 none code", {5'b0, pend}, 6'h00);
    end
  endtask

  task automatic t_sync_b();
    trig_sel = 3'd0; sync_sel = 2'd2;
    wr(6'h2a, 1);
    chk("R5 req arms", {5'b0, pend}, 6'h01);
    ta_zm = 1; step();
    chk("R3 other zm ignored", act, cur);
    chk("R3 pend kept", {5'b0, pend}, 6'h01);
    tb_zm = 1; step();
    chk("R3 copy B", act, 6'h2a);
    chk("R3 pend clr B", {5'b0, pend}, 6'h00);
    cur = 6'h2a;
  endtask

  task automatic t_direct();
    sync_sel = 2'd3; trig_sel = 3'd0;
    wr(6'h15, 1);
    chk("R4 direct sw", act, 6'h15);
    chk("R4 pend zero", {5'b0, pend}, 6'h00);
    wr(6'h33, 0);
    chk("R9 no req", act, 6'h15);
    chk("R9 no pend", {5'b0, pend}, 6'h00);
    trig_sel = 3'd4; evt[3] = 1; step();
    chk("R4 direct hw", act, 6'h33);
    chk("R4 pend zero hw", {5'b0, pend}, 6'h00);
    cur = 6'h33;
  endtask

  task automatic t_same();
    sync_sel = 2'd1; trig_sel = 3'd3;
    wr(6'h0c, 0);
    evt[2] = 1; ta_zm = 1; step();
    chk("R7 same-cycle copy", act, 6'h0c);
    chk("R7 pend clear", {5'b0, pend}, 6'h00);
    cur = 6'h0c;
  endtask

  task automatic t_none();
    sync_sel = 2'd0; trig_sel = 3'd0;
    wr(6'h3c, 1);
    ta_zm = 1; tb_zm = 1; step();
    chk("R6 no copy", act, cur);
    chk("R6 pend held", {5'b0, pend}, 6'h01);
    sync_sel = 2'd3; step();
    chk("R6 later direct", act, 6'h3c);
    chk("R6 pend clr", {5'b0, pend}, 6'h00);
    cur = 6'h3c;
  endtask

  task automatic t_idle();
    sync_sel = 2'd1; trig_sel = 3'd0;
    wr(6'h21, 1);
    idle = 1; ta_zm = 1; step();
    chk("R8 idle clears", act, 6'h00);
    chk("R8 pend kept", {5'b0, pend}, 6'h01);
    idle = 0; ta_zm = 1; step();
    chk("R8 copy after idle", act, 6'h21);
    chk("R8 pend clr", {5'b0, pend}, 6'h00);
    idle = 1; step();
    chk("R8 idle alone", act, 6'h00);
    idle = 0; step();
    chk("R8 stays clear", act, 6'h00);
  endtask

  initial begin
    fork
      begin
        #5; rst_n = 1; #1;
        t_reset(); t_trig(); t_sync_b(); t_direct(); t_same(); t_none(); t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule